// File: doc/BRIEF.md
# Pairwise State Product Generator

This block feeds the quadratic term evaluation of a multivariate quadratic keystream generator over GF(2). Every output bit of one evaluation pass depends on the products x_i·x_j of the state bits, taken over all distinct pairs i≠j. For a 128-bit state there are 8128 such pairs. The block produces them 128 at a time, one vector per clock, over a fixed pass of 64 cycles.

A start pulse captures the state word. The first working register then holds that word unchanged, and a second holds a copy that turns one more bit position toward the MSB on every output cycle. The product vector is the bitwise AND of the two registers. A cycle index runs beside the vectors and acts as the read address shared by the coefficient memories downstream. A valid strobe marks each vector, and a done pulse marks the last one. In the last cycle the upper half of the vector repeats the lower half. Those duplicates are passed through, and zero coefficients downstream cancel them.

Top module: `pair_product_gen`

## Requirements
- R1: After reset, valid_o and done_o are 0, idx_o is 0 and prod_o is all zeros.
- R2: A start accepted on a clock edge makes valid_o high from the next edge, for exactly PASS_CYC consecutive cycles (64 at the default width), and then low again.
- R3: The k-th vector of a pass (k from 0) equals x AND rotl(x, k+1). Here x is the captured state and rotl turns toward the MSB, with bit W-1 wrapping into bit 0, so bit i is x[i]·x[(i-k-1) mod W].
- R4: idx_o equals k while vector k is valid, rising by one per valid cycle from 0 to PASS_CYC-1.
- R5: done_o is high for exactly one cycle, together with the last valid vector (idx_o = PASS_CYC-1), and never at any other time.
- R6: In the last vector of a pass, bits W-1..W/2 equal bits W/2-1..0, and both halves are passed through unmasked.
- R7: A start pulse that arrives while a pass is running, including on the edge that produces its last vector, is ignored, and the running pass continues unchanged.
- R8: Changes on state_i after the start has been captured have no effect on the running pass.
- R9: A start held high while done_o is high is accepted. The next pass then begins after one cycle in which valid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begins a pass when idle |
| state_i | input | W | State word captured on an accepted start |
| prod_o | output | W | Registered pairwise product vector |
| idx_o | output | $clog2(W/2) | Cycle index / coefficient read address |
| valid_o | output | 1 | High while prod_o holds a vector of the pass |
| done_o | output | 1 | High with the last vector of the pass |

## Verification
The assertions rely on two things about the inputs. Reset is held for at least one clock edge before any start arrives. The width W is even, so that the pass length W/2 is an integer and the two halves of the last vector line up. The stimulus holds reset for several edges and uses the default even width. It drives start and state at falling edges only, so no start lands on an edge that resets the block. The ignored-start and state-change cases are placed in the middle of a pass and on its final edge, where their effect could show in the vectors that follow.

// File: rtl/pair_gen_pkg.sv
package pair_gen_pkg;
  typedef enum logic {PH_IDLE = 1'b0, PH_RUN = 1'b1} pass_phase_e;
endpackage

// File: rtl/pair_pass_ctrl.sv
module pair_pass_ctrl
  import pair_gen_pkg::*;
#(
  parameter int PASS_CYC = 64,
  localparam int IDX_W = $clog2(PASS_CYC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  output logic             load_o,
  output logic             adv_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             valid_o,
  output logic             done_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(PASS_CYC - 1);

  pass_phase_e      phase_q;
  logic [IDX_W-1:0] cnt_q;
  logic             last_c;

  assign load_o = (phase_q == PH_IDLE) && start_i;
  assign adv_o  = (phase_q == PH_RUN);
  assign last_c = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      idx_o   <= '0;
      valid_o <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      valid_o <= adv_o;
      done_o  <= adv_o && last_c;
      if (adv_o) idx_o <= cnt_q;
      if (load_o) begin
        phase_q <= PH_RUN;
        cnt_q   <= '0;
      end else if (adv_o) begin
        cnt_q <= cnt_q + 1'b1;
        if (last_c) phase_q <= PH_IDLE;
      end
    end
  end

  // R5
  done_only_last_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (valid_o && idx_o == LAST));

  // R4
  idx_step_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !done_o) |=> (valid_o && idx_o == $past(idx_o) + 1'b1));

  // R2
  valid_first_idx_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(valid_o) |-> (idx_o == '0));

  // R7
  run_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (adv_o && !last_c) |=> adv_o);
endmodule

// File: rtl/pair_rot_regs.sv
module pair_rot_regs #(
  parameter int W = 128
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic         adv_i,
  input  logic [W-1:0] state_i,
  output logic [W-1:0] fix_o,
  output logic [W-1:0] rot_o
);
  logic [W-1:0] load_rot_c;
  logic [W-1:0] step_rot_c;

  // one-position turn toward the MSB, top bit wraps into bit 0
  assign load_rot_c = {state_i[W-2:0], state_i[W-1]};
  assign step_rot_c = {rot_o[W-2:0], rot_o[W-1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      fix_o <= '0;
      rot_o <= '0;
    end else if (load_i) begin
      fix_o <= state_i;
      rot_o <= load_rot_c;
    end else if (adv_i) begin
      rot_o <= step_rot_c;
    end
  end

  // R8
  fix_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(load_i) |-> $stable(fix_o));

  // R3
  rot_weight_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(load_i) |-> ($countones(rot_o) == $countones(fix_o)));
endmodule

// File: rtl/pair_and_stage.sv
module pair_and_stage #(
  parameter int W     = 128,
  parameter int SLICE = 32,
  localparam int NSL  = (W + SLICE - 1) / SLICE
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] prod_o
);
  for (genvar s = 0; s < NSL; s++) begin : g_slice
    localparam int LO = s * SLICE;
    localparam int HI = ((s + 1) * SLICE > W) ? W - 1 : (s + 1) * SLICE - 1;
    always_ff @(posedge clk) begin
      if (rst) prod_o[HI:LO] <= '0;
      else if (en_i) prod_o[HI:LO] <= a_i[HI:LO] & b_i[HI:LO];
    end
  end
endmodule

// File: rtl/pair_product_gen.sv
module pair_product_gen #(
  parameter int W = 128,
  localparam int PASS_CYC = W / 2,
  localparam int IDX_W = $clog2(PASS_CYC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [W-1:0]     state_i,
  output logic [W-1:0]     prod_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             valid_o,
  output logic             done_o
);
  logic         load_c;
  logic         adv_c;
  logic [W-1:0] fix_q;
  logic [W-1:0] rot_q;

  pair_pass_ctrl #(.PASS_CYC(PASS_CYC)) u_ctrl (
    .clk(clk), .rst(rst), .start_i(start_i),
    .load_o(load_c), .adv_o(adv_c),
    .idx_o(idx_o), .valid_o(valid_o), .done_o(done_o)
  );

  pair_rot_regs #(.W(W)) u_regs (
    .clk(clk), .rst(rst), .load_i(load_c), .adv_i(adv_c),
    .state_i(state_i), .fix_o(fix_q), .rot_o(rot_q)
  );

  pair_and_stage #(.W(W)) u_and (
    .clk(clk), .rst(rst), .en_i(adv_c),
    .a_i(fix_q), .b_i(rot_q), .prod_o(prod_o)
  );

  // R6
  last_halves_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (prod_o[W-1:W/2] == prod_o[W/2-1:0]));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> !done_o);
endmodule

// File: tb/pair_product_gen_bench.sv
module pair_product_gen_bench;
  localparam int W = 128;
  localparam int P = W / 2;
  localparam int IW = $clog2(P);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0;
  logic [W-1:0]  state_i = '0;
  logic [W-1:0]  prod_o;
  logic [IW-1:0] idx_o;
  logic          valid_o;
  logic          done_o;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  pair_product_gen #(.W(W)) u_pair_product_gen (
    .clk(clk), .rst(rst), .start_i(start_i), .state_i(state_i),
    .prod_o(prod_o), .idx_o(idx_o), .valid_o(valid_o), .done_o(done_o)
  );

  function automatic logic [W-1:0] rotl(input logic [W-1:0] v, input int n);
    logic [W-1:0] r;
    r = v;
    for (int s = 0; s < n; s++) r = {r[W-2:0], r[W-1]};
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // pre: start already presented at previous falling edge
  task automatic run_pass(input logic [W-1:0] x, input bit pre, input bit pert,
                          input bit chain, input logic [W-1:0] nx);
    if (!pre) begin
      @(negedge clk); start_i = 1'b1; state_i = x;
    end
    @(negedge clk); start_i = 1'b0;
    chk(valid_o == 1'b0, "R2/R9 gap before pass", W'(valid_o), '0);
    for (int k = 0; k < P; k++) begin
      @(negedge clk);
      start_i = 1'b0;
      chk(valid_o == 1'b1, "R2 valid", W'(valid_o), W'(1));
      chk(idx_o == IW'(k), "R4 idx", W'(idx_o), W'(k));
      chk(prod_o == (x & rotl(x, k + 1)), "R3/R7/R8 product", prod_o, x & rotl(x, k + 1));
      chk(done_o == (k == P - 1), "R5 done", W'(done_o), W'(k == P - 1));
      if (k == P - 1)
        chk(prod_o[W-1:W/2] == prod_o[W/2-1:0], "R6 halves", W'(prod_o[W-1:W/2]),
            W'(prod_o[W/2-1:0]));
      if (pert && (k == 10 || k == P - 2)) begin
        start_i = 1'b1; state_i = ~x;
      end else begin
        state_i = pert ? (x ^ W'(k)) : x;
      end
      if (chain && k == P - 1) begin
        start_i = 1'b1; state_i = nx;
      end
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1 reset state
    chk(valid_o == 1'b0, "R1 valid", W'(valid_o), '0);
    chk(done_o == 1'b0, "R1 done", W'(done_o), '0);
    chk(idx_o == '0, "R1 idx", W'(idx_o), '0);
    chk(prod_o == '0, "R1 prod", prod_o, '0);

    run_pass({W{1'b1}}, 1'b0, 1'b0, 1'b0, '0);
    run_pass({(W/2){2'b10}}, 1'b0, 1'b0, 1'b0, '0);
    run_pass(W'(1) | (W'(1) << (W - 1)), 1'b0, 1'b0, 1'b0, '0);
    // R7, R8: starts and state changes mid-pass and on the final edge
    run_pass({4{32'hC3A5_9E17}}, 1'b0, 1'b1, 1'b0, '0);
    // R9: chained start while done is high
    run_pass({32{4'h6}} ^ (W'(1) << 77), 1'b0, 1'b0, 1'b1, {8{16'h1F2D}});
    run_pass({8{16'h1F2D}}, 1'b1, 1'b0, 1'b0, '0);

    // R2 back to idle after the pass
    @(negedge clk);
    chk(valid_o == 1'b0, "R2 idle after pass", W'(valid_o), '0);
    chk(done_o == 1'b0, "R5 idle done", W'(done_o), '0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule